// File: doc/BRIEF.md
# Write-Through Invalidate Snooping Cache Controller

This controller sits between one processor and a shared, atomic bus. It manages a small direct-mapped, write-through cache with one data word per line. Each line is either Valid or Invalid. Alongside the state bit, each line keeps a tag and a data word. A line that has never been filled counts as Invalid.

A processor read that hits a Valid line completes without touching the bus. A read miss asks for the bus, performs a bus read, and fills the line. Every processor write goes to the bus, because the cache is write-through. A write that hits also updates the local copy. A write that misses does not allocate a line.

The controller watches the bus continuously. When another cache writes a block that this cache holds, the local line is invalidated in the same cycle. Requester IDs on the bus let the controller ignore its own transactions.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_done` is low and `bus_req` is low.
- R2: A read request that hits a Valid line with a matching tag raises `cpu_done` for one cycle, in the cycle after the request is accepted. `cpu_rdata` then holds the cached word, and `bus_req` is never raised for that request.
- R3: A read miss raises `bus_req` with `bus_we` low in the cycle after acceptance. `cpu_done` follows one cycle after the granted cycle, carrying the `bus_rdata` sampled in the granted cycle. The line then becomes Valid, holding that tag and data. A fill replaces whatever tag the line held before.
- R4: Every write request raises `bus_req` with `bus_we` high, with `bus_addr` equal to `cpu_addr` and `bus_wdata` equal to `cpu_wdata`. This holds for hits and misses alike. `cpu_done` rises one cycle after the granted cycle.
- R5: A write that hits updates the cached word, and the line stays Valid. A later read then hits and returns the written value.
- R6: A write that misses leaves the line unchanged, so a later read of that address misses.
- R7: A snooped bus write (`snp_valid` and `snp_we` high) from another requester ID, to an address whose line is Valid with a matching tag, makes that line Invalid at the next clock edge.
- R8: A snooped transaction has no effect on the cache in any of these cases: it carries this cache's own ID (`MY_ID`), it is a read, or its tag differs from the held tag.
- R9: An invalidating snoop takes priority over a processor read to the same line in the same cycle. That read is treated as a miss and goes to the bus.
- R10: `bus_req`, `bus_we` and `bus_addr` stay unchanged until `bus_gnt` is seen. `cpu_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | Request is a write |
| cpu_addr | input | ADDR_W | Word address; the low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus request, held until granted |
| bus_gnt | input | 1 | Grant; the transaction completes in the granted cycle |
| bus_we | output | 1 | Bus transaction is a write |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_rdata | input | DATA_W | Memory data returned in the granted cycle |
| snp_valid | input | 1 | A transaction is on the bus this cycle |
| snp_we | input | 1 | The observed transaction is a write |
| snp_id | input | ID_W | Requester ID of the observed transaction |
| snp_addr | input | ADDR_W | Address of the observed transaction |

## Verification
A stale Valid bit, a wrong tag or stale data only becomes visible at the ports when the affected line is next read.

The symptom appears in the cycle after acceptance:
- A line wrongly held Valid produces a `cpu_done` pulse with no preceding `bus_req`, returning old data.
- A line wrongly dropped to Invalid produces an unexpected bus read.

The bench therefore reads each line back after every write, snoop and fill. It compares `cpu_done`, `bus_req` and the bus fields on every cycle, so a divergence is reported one cycle after it occurs.

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic              snp_we,
  input  logic [ID_W-1:0]   snp_id,
  input  logic [ADDR_W-1:0] snp_addr
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_RESP} st_t;
  st_t state;

  logic [LINES-1:0]  vld;
  logic [TAG_W-1:0]  tags [LINES];
  logic [DATA_W-1:0] words [LINES];
  logic [DATA_W-1:0] rdata_q;

  wire [IDX_W-1:0] c_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] s_idx = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snp_addr[ADDR_W-1:IDX_W];

  wire snp_kill = snp_valid && snp_we && (snp_id != ID_W'(MY_ID))
                  && vld[s_idx] && (tags[s_idx] == s_tag);
  wire c_match  = vld[c_idx] && (tags[c_idx] == c_tag);
  wire rd_hit   = cpu_req && !cpu_we && c_match && !(snp_kill && s_idx == c_idx);
  wire granted  = (state == S_BUS) && bus_gnt;

  assign bus_req   = (state == S_BUS);
  assign bus_we    = cpu_we;
  assign bus_addr  = cpu_addr;
  assign bus_wdata = cpu_wdata;
  assign cpu_done  = (state == S_RESP);
  assign cpu_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE:  if (cpu_req) state <= rd_hit ? S_RESP : S_BUS;
        S_BUS:   if (bus_gnt) state <= S_RESP;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_IDLE && rd_hit) rdata_q <= words[c_idx];
    else if (granted && !cpu_we)   rdata_q <= bus_rdata;
  end

  always_ff @(posedge clk) begin
    if (granted && !cpu_we) begin
      tags[c_idx]  <= c_tag;
      words[c_idx] <= bus_rdata;
    end else if (granted && cpu_we && c_match) begin
      words[c_idx] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      if (granted && !cpu_we) vld[c_idx] <= 1'b1;
      if (snp_kill)           vld[s_idx] <= 1'b0;
    end
  end

  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we))); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R10
  AST_WRITE_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && cpu_we) |-> $past(bus_req && bus_gnt && bus_we)); // R4
  AST_SNOOP_KILL: assert property (@(posedge clk) disable iff (!rst_n)
    snp_kill |=> !vld[$past(s_idx)]); // R7
  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && rd_hit) |=> (cpu_done && !bus_req)); // R2
endmodule

// File: tb/wt_snoop_ctrl_bench.sv
module wt_snoop_ctrl_bench;
  localparam int AW = 16, DW = 32, IW = 4, IDW = 2, ME = 1;
  localparam int NL = 1 << IW;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata, bus_wdata, bus_rdata;
  logic cpu_done, bus_req, bus_gnt = 0, bus_we;
  logic [AW-1:0] bus_addr;
  logic snp_valid = 0, snp_we = 0;
  logic [IDW-1:0] snp_id = '0;
  logic [AW-1:0] snp_addr = '0;

  always #10 clk = ~clk;

  wt_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .ID_W(IDW), .MY_ID(ME)) u_wt_snoop_ctrl (
    .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata, .cpu_done,
    .bus_req, .bus_gnt, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .snp_valid, .snp_we, .snp_id, .snp_addr);

  logic [DW-1:0] mem [int];
  function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return {a ^ 16'h5A3C, a};
  endfunction
  always_comb bus_rdata = mem_rd(bus_addr);

  int checks = 0, fails = 0, cycles = 0;
  string tag = "R1";

  task automatic chk(input bit ok, input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", r, act, exp, $time);
    end
  endtask

  // reference model
  int m_state = 0;
  bit m_vld [NL];
  int m_tag [NL];
  logic [DW-1:0] m_dat [NL];
  logic [DW-1:0] m_rdata;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0;
      foreach (m_vld[i]) m_vld[i] = 0;
    end else begin
      int ci, ct, si, st;
      bit kill, hit;
      ci = int'(cpu_addr) % NL; ct = int'(cpu_addr) / NL;
      si = int'(snp_addr) % NL; st = int'(snp_addr) / NL;
      kill = snp_valid && snp_we && (int'(snp_id) != ME) && m_vld[si] && m_tag[si] == st;
      hit  = m_vld[ci] && m_tag[ci] == ct;
      if (m_state == 0) begin
        if (cpu_req) begin
          if (!cpu_we && hit && !(kill && si == ci)) begin
            m_rdata = m_dat[ci]; m_state = 2;
          end else m_state = 1;
        end
      end else if (m_state == 1) begin
        if (bus_gnt) begin
          if (cpu_we) begin
            mem[int'(cpu_addr)] = cpu_wdata;
            if (hit) m_dat[ci] = cpu_wdata;
          end else begin
            m_rdata = mem_rd(cpu_addr);
            m_vld[ci] = 1; m_tag[ci] = ct; m_dat[ci] = m_rdata;
          end
          m_state = 2;
        end
      end else m_state = 0;
      if (kill) m_vld[si] = 0;
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(cpu_done == (m_state == 2), tag, DW'(cpu_done), DW'(m_state == 2));
    chk(bus_req == (m_state == 1), tag, DW'(bus_req), DW'(m_state == 1));
    if (cpu_done && !cpu_we) chk(cpu_rdata == m_rdata, tag, cpu_rdata, m_rdata);
    if (bus_req) begin
      chk(bus_we == cpu_we && bus_addr == cpu_addr, tag, DW'(bus_addr), DW'(cpu_addr));
      if (cpu_we) chk(bus_wdata == cpu_wdata, tag, bus_wdata, cpu_wdata);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic op(input string r, input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input int dly, input bit with_snp = 0, input logic [AW-1:0] sa = '0);
    int n = 0;
    tag = r;
    @(negedge clk); #1;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    if (with_snp) begin
      snp_valid = 1; snp_we = 1; snp_id = 2; snp_addr = sa;
      mem[int'(sa)] = 32'hC0DE_0000 | DW'(sa);
    end
    forever begin
      @(negedge clk); #1;
      snp_valid = 0;
      if (cpu_done) begin cpu_req = 0; bus_gnt = 0; break; end
      if (bus_req) begin bus_gnt = (n == dly); n++; end
      else bus_gnt = 0;
    end
  endtask

  task automatic snoop(input string r, input bit we, input logic [IDW-1:0] id, input logic [AW-1:0] a);
    tag = r;
    @(negedge clk); #1;
    snp_valid = 1; snp_we = we; snp_id = id; snp_addr = a;
    if (we && id != ME) mem[int'(a)] = 32'hBEEF_0000 | DW'(a);
    @(negedge clk); #1;
    snp_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!cpu_done && !bus_req, "R1", DW'({cpu_done, bus_req}), '0);
    op("R3", 0, 16'h0013, '0, 2);
    op("R2", 0, 16'h0013, '0, 0);
    op("R4", 1, 16'h0013, 32'hA5A5_0001, 1);
    op("R5", 0, 16'h0013, '0, 0);
    op("R4", 1, 16'h0024, 32'h1234_5678, 0);
    op("R6", 0, 16'h0024, '0, 1);
    snoop("R7", 1, 2, 16'h0013);
    op("R7", 0, 16'h0013, '0, 0);
    snoop("R8", 1, 1, 16'h0024);
    op("R8", 0, 16'h0024, '0, 0);
    snoop("R8", 0, 2, 16'h0024);
    op("R8", 0, 16'h0024, '0, 0);
    snoop("R8", 1, 3, 16'h1024);
    op("R8", 0, 16'h0024, '0, 0);
    op("R9", 0, 16'h0024, '0, 1, 1, 16'h0024);
    op("R3", 0, 16'h1013, '0, 0);
    op("R3", 0, 16'h0013, '0, 3);
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a;
      a = AW'((i * 7) % 24);
      op("R4", (i % 3) == 0, a, DW'(i * 32'h0101_0101), i % 3);
      op("R10", 0, a, '0, i % 2);
      if (i % 5 == 0) snoop("R7", 1, 2, a);
    end
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule